// File: doc/BRIEF.md
# Alternating-Polarity Slave Clock Pulse Steerer

This block turns a debounced master-clock pulse that arrives twice a minute into drive for a slave clock motor. The motor must step once a minute, and each step must have the opposite polarity to the one before. The block counts input pulses since reset and forwards only every second one. It sends the forwarded pulses in turn to two outputs, and those two outputs feed the two inputs of an external H-bridge. Each output therefore fires once every two minutes, and the two outputs together give one drive pulse per minute with alternating polarity.

The master pulse is asynchronous and lasts about a third of a second. The block samples it through a synchroniser chain on a fast system clock. A two-bit phase count moves forward only when the synchronised pulse ends. Because of this, the routing never changes while a pulse is live, and no output can produce a short glitch at the start of a pulse. Each output is a registered, gated copy of the synchronised input. Its length matches the input pulse, and no pulse is regenerated. The logic holds no timer, so it works at any pulse rate or length.

Top module: `alt_pulse_steerer`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, both `driveP1` and `driveP2` are low and the phase count is zero.
- R2: The first input pulse after reset appears on `driveP1`.
- R3: Input pulses are numbered from 0 after reset. Pulse n goes to `driveP1` when n mod 4 is 0, goes to `driveP2` when n mod 4 is 2, and drives neither output when n is odd.
- R4: A forwarded pulse rises on its output SYNC_STAGES+1 clock edges after the input is first sampled high. It stays high for exactly as many clock cycles as the input was sampled high.
- R5: The phase count moves forward only on the clock after the synchronised input falls. A pulse of any length keeps a single output continuously high and never moves to the other output partway through.
- R6: `driveP1` and `driveP2` are never high in the same cycle.
- R7: An input pulse only one clock cycle long, including one that follows a one-cycle gap, is counted like any other pulse. When it is forwarded, it appears as a one-cycle output pulse.
- R8: A reset applied partway through a sequence restarts the pulse numbering, so the next pulse goes to `driveP1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than the master pulse |
| rst | input | 1 | Synchronous active-high reset |
| masterPulse | input | 1 | Debounced master-clock pulse, asynchronous to `clk` |
| driveP1 | output | 1 | First polarity drive to the H-bridge |
| driveP2 | output | 1 | Second polarity drive to the H-bridge |

## Verification
A level the bench drives on the master input shows up on an output SYNC_STAGES+1 clock edges later. That delay comes from the synchroniser stages plus the output register. The bench keeps a short history of what it drove and, for each entry, which output the pulse should go to. It compares each output against the history entry from exactly that many cycles back, so both output width and output timing are checked on every cycle. Inputs change on the falling clock edge, and outputs are read on the same falling edge before the new input is applied. This keeps every comparison half a period away from the edge where the design updates.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int PHASE_W = 2;

  typedef logic [PHASE_W-1:0] phase_t;

  // Strobes from the control module that tell the datapath where to gate the pulse
  typedef struct packed {
    logic routeP1;
    logic routeP2;
  } route_t;

endpackage

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   masterPulse,
  input  route_t route,
  output logic   syncPulse,
  output logic   driveP1,
  output logic   driveP2
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [SYNC_STAGES-1:0] stageIn;

  // Synchroniser chain: one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      assign stageIn[g] = masterPulse;
    end else begin : g_rest
      assign stageIn[g] = syncChain[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) syncChain[g] <= 1'b0;
      else     syncChain[g] <= stageIn[g];
    end
  end

  assign syncPulse = syncChain[SYNC_STAGES-1];

  // Registered gating: each output is a copy of the live pulse while it is routed there
  always_ff @(posedge clk) begin
    if (rst) begin
      driveP1 <= 1'b0;
      driveP2 <= 1'b0;
    end else begin
      driveP1 <= syncPulse & route.routeP1;
      driveP2 <= syncPulse & route.routeP2;
    end
  end

endmodule

// File: rtl/steer_control.sv
module steer_control
  import steer_pkg::*;
#(
  parameter int P1_PHASE = 0,
  parameter int P2_PHASE = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   syncPulse,
  output route_t route,
  output phase_t phase
);

  localparam phase_t P1_SEL = phase_t'(P1_PHASE);
  localparam phase_t P2_SEL = phase_t'(P2_PHASE);

  logic prevSync;
  logic fallStrobe;

  always_ff @(posedge clk) begin
    if (rst) prevSync <= 1'b0;
    else     prevSync <= syncPulse;
  end

  // Trailing edge only: the phase never moves while a pulse is high
  assign fallStrobe = prevSync & ~syncPulse;

  always_ff @(posedge clk) begin
    if (rst)             phase <= '0;
    else if (fallStrobe) phase <= phase + phase_t'(1);
  end

  always_comb begin
    route.routeP1 = (phase == P1_SEL);
    route.routeP2 = (phase == P2_SEL);
  end

endmodule

// File: rtl/alt_pulse_steerer.sv
module alt_pulse_steerer
  import steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int P1_PHASE    = 0,
  parameter int P2_PHASE    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic masterPulse,
  output logic driveP1,
  output logic driveP2
);

  route_t routeNow;
  phase_t phaseNow;
  logic   syncPulse;

  steer_control #(
    .P1_PHASE(P1_PHASE),
    .P2_PHASE(P2_PHASE)
  ) u_control (
    .clk      (clk),
    .rst      (rst),
    .syncPulse(syncPulse),
    .route    (routeNow),
    .phase    (phaseNow)
  );

  steer_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .masterPulse(masterPulse),
    .route      (routeNow),
    .syncPulse  (syncPulse),
    .driveP1    (driveP1),
    .driveP2    (driveP2)
  );

endmodule

// File: rtl/steer_checker.sv
module steer_checker
  import steer_pkg::*;
#(
  parameter int P1_PHASE = 0,
  parameter int P2_PHASE = 2
) (
  input logic   clk,
  input logic   rst,
  input logic   syncPulse,
  input phase_t phase,
  input logic   driveP1,
  input logic   driveP2
);

  logic lastWasP1;

  always_ff @(posedge clk) begin
    if (rst)                      lastWasP1 <= 1'b0;
    else if (driveP1 && !driveP2) lastWasP1 <= 1'b1;
    else if (driveP2 && !driveP1) lastWasP1 <= 1'b0;
  end

  // R1: reset clears outputs and phase
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!driveP1 && !driveP2 && phase == '0));

  // R3: a pulse on P1 must follow a P2 pulse or reset, and a pulse on P2 must follow a P1 pulse
  a_r3_p1_alternates: assert property (@(posedge clk) disable iff (rst)
    $rose(driveP1) |-> !lastWasP1);
  a_r3_p2_alternates: assert property (@(posedge clk) disable iff (rst)
    $rose(driveP2) |-> lastWasP1);

  // R3: an output is high only in its own phase
  a_r3_p1_phase: assert property (@(posedge clk) disable iff (rst)
    driveP1 |-> (phase == phase_t'(P1_PHASE)));
  a_r3_p2_phase: assert property (@(posedge clk) disable iff (rst)
    driveP2 |-> (phase == phase_t'(P2_PHASE)));

  // R4: an output is only high one cycle after the synchronised pulse was high
  a_r4_p1_copy: assert property (@(posedge clk) disable iff (rst)
    driveP1 |-> $past(syncPulse));
  a_r4_p2_copy: assert property (@(posedge clk) disable iff (rst)
    driveP2 |-> $past(syncPulse));

  // R5: the phase moves only after the synchronised pulse falls
  a_r5_fall_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && phase != $past(phase)) |-> ($past(syncPulse, 2) && !$past(syncPulse)));

  // R6: the outputs never overlap
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(driveP1 && driveP2));

endmodule

bind alt_pulse_steerer steer_checker #(
  .P1_PHASE(P1_PHASE),
  .P2_PHASE(P2_PHASE)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .syncPulse(syncPulse),
  .phase    (phaseNow),
  .driveP1  (driveP1),
  .driveP2  (driveP2)
);

// File: tb/alt_pulse_steerer_bench.sv
module alt_pulse_steerer_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam int LAT         = SYNC_STAGES + 1;
  localparam int HIST        = 8;
  localparam int WATCHDOG    = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic masterPulse = 1'b0;
  logic driveP1;
  logic driveP2;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_pulse_steerer #(.SYNC_STAGES(SYNC_STAGES)) u_alt_pulse_steerer (
    .clk        (clk),
    .rst        (rst),
    .masterPulse(masterPulse),
    .driveP1    (driveP1),
    .driveP2    (driveP2)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  int    cyc = 0;
  bit    histVal[HIST];
  int    histRoute[HIST];
  int    pulseIdx = -1;
  int    curRoute = 0;
  bit    lastIn = 1'b0;
  string tag = "R1";

  // R3: pulse n -> 1 (P1) when n mod 4 == 0, 2 (P2) when n mod 4 == 2, else 0
  function automatic int routeFor(int idx);
    case (idx % 4)
      0:       return 1;
      2:       return 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < HIST; i++) begin
      histVal[i]   = 1'b0;
      histRoute[i] = 0;
    end
    pulseIdx = -1;
    curRoute = 0;
    lastIn   = 1'b0;
  endtask

  task automatic step(bit newIn);
    int k;
    bit expP1;
    bit expP2;
    @(negedge clk);
    cyc++;
    k = ((cyc - LAT) % HIST + HIST) % HIST;
    expP1 = histVal[k] && (histRoute[k] == 1);
    expP2 = histVal[k] && (histRoute[k] == 2);
    check("R6", driveP1 && driveP2, 1'b0);
    check(tag, driveP1, expP1);
    check(tag, driveP2, expP2);
    masterPulse = newIn;
    if (newIn && !lastIn) begin
      pulseIdx++;
      curRoute = routeFor(pulseIdx);
    end
    lastIn = newIn;
    histVal[cyc % HIST]   = newIn;
    histRoute[cyc % HIST] = curRoute;
  endtask

  task automatic pulse(int width, int gap);
    repeat (width) step(1'b1);
    repeat (gap) step(1'b0);
  endtask

  task automatic applyReset(int n);
    step(1'b0);
    rst = 1'b1;
    clearModel();
    tag = "R1";
    repeat (n) step(1'b0);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    clearModel();

    // R1: reset state, held a few cycles then released
    tag = "R1";
    repeat (4) step(1'b0);
    rst = 1'b0;
    repeat (3) step(1'b0);

    // R2: first pulse after reset lands on P1
    tag = "R2";
    pulse(5, 10);

    // R3: the rest of the four-pulse cycle, then another full cycle
    tag = "R3";
    pulse(4, 6);
    pulse(7, 3);
    pulse(2, 9);
    pulse(3, 4);
    pulse(6, 5);
    pulse(8, 8);
    pulse(5, 7);

    // R7: single-cycle pulses, including one-cycle gaps
    tag = "R7";
    pulse(1, 5);
    pulse(1, 1);
    pulse(1, 1);
    pulse(1, 1);
    pulse(1, 6);

    // R5: long pulses never switch output mid-pulse
    tag = "R5";
    repeat (4) pulse(60, 5);

    // R8: reset in the middle of the sequence restarts numbering
    tag = "R8";
    pulse(6, 6);
    applyReset(3);
    tag = "R8";
    pulse(5, 5);
    pulse(5, 5);

    // R4: random widths and gaps, output width and delay checked every cycle
    tag = "R4";
    for (int i = 0; i < 200; i++) begin
      pulse(int'($urandom_range(40, 1)), int'($urandom_range(40, 1)));
    end
    repeat (LAT + 3) step(1'b0);

    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
      finishRun();
    end
  end

endmodule